// File: doc/BRIEF.md
# Serial Clock-Chip Register Programmer

This block loads the configuration registers of an external clock-conditioning device over a three-line serial link made of a serial clock, a serial data line and a latch-enable strobe. A single-cycle start request launches a fixed programming sequence. The sequence sends a reset command word first, then each configured register word, and the device stores each word when the strobe pulses.

Each configured word is built from two 16-bit halves taken from two packed input vectors. The upper half comes from one vector and the lower half from the other. The serial clock is divided down from the system clock. With the defaults, a 50 MHz system clock and a divide ratio of 25 give a 2 MHz link.

The configured values are meant to encode their own register number in their low bits, for example 0x00000103 for register 3. The block sends those bits unchanged and does not compute them. It raises a busy flag for the length of the sequence and a done pulse when the sequence ends. The configuration inputs must be held stable while busy is high.

Top module: `clkcfg_serial_prog`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `sclk`, `sdata`, `le`, `busy` and `done` are all 0.
- R2: A start request sampled while idle makes `busy` high from the next cycle on. The first data bit appears on `sdata` in that same cycle, with `sclk` low.
- R3: Each serial bit lasts SCLK_DIV system cycles. `sclk` is low for the first SCLK_DIV/2 of those cycles and high for the rest.
- R4: Words are sent most significant bit first. `sdata` changes only at the start of a bit period, which is where `sclk` falls, and it stays stable while `sclk` is high.
- R5: The first word of every sequence is the reset word, 0x80000000 by default.
- R6: Words 1 to NUM_WORDS-1 follow in index order. Word k is {cfg_hi[(k-1)*16 +: 16], cfg_lo[(k-1)*16 +: 16]}.
- R7: `le` stays low while a word shifts. After the 32nd bit of each word, `le` is high for exactly SCLK_DIV cycles with `sclk` and `sdata` low, so each strobe follows exactly 32 clock rises.
- R8: After the strobe of the last word, `done` is high for exactly one cycle and `busy` falls in that same cycle. A whole sequence takes NUM_WORDS*33*SCLK_DIV cycles, and exactly NUM_WORDS strobes are produced.
- R9: A start request that arrives while busy is ignored: the running sequence keeps its timing and word count. A start request in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled while idle |
| cfg_hi | input | (NUM_WORDS-1)*HALF_W | Upper halves of the configured words, entry k-1 for word k |
| cfg_lo | input | (NUM_WORDS-1)*HALF_W | Lower halves of the configured words, entry k-1 for word k |
| sclk | output | 1 | Serial clock to the device |
| sdata | output | 1 | Serial data, most significant bit first |
| le | output | 1 | Latch-enable strobe after each word |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
A behavioural model predicts every output on every cycle from a cycle count since start. A separate bench receiver samples `sdata` on each `sclk` rise and collects a word on each strobe, and these words are compared against the halves that were assembled.

A design that swapped the halves, shifted least significant bit first or skipped the reset word would produce wrong collected words. A design that moved data while `sclk` was high would break sampling on the clock rise. A latch period that was too short, or one that overlapped a clock pulse, would show up as a wrong bit count per strobe.

The bench fires a start request in the middle of a sequence, which a design that restarted would answer with extra words and a longer busy period. It also fires a start request in the cycle where `done` is high, which a design that missed it would answer with no second sequence.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_LATCH = 2'd2
   } prog_state_t;

endpackage

// File: rtl/clkcfg_sclk_gen.sv
module clkcfg_sclk_gen #(
   parameter int SCLK_DIV = 25
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic period_end,
   output logic high_phase
);
   localparam int CNT_W   = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
   localparam int LOW_CYC = SCLK_DIV / 2;
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SCLK_DIV - 1);
   localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_CYC);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt == LAST_C) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign period_end = run && (cnt == LAST_C);
   assign high_phase = (cnt >= LOW_C);

   // R3: the phase counter never leaves its period
   assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST_C);

   // R3: an idle counter starts each sequence at phase zero
   assert_cnt_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !run |=> cnt == '0);

endmodule

// File: rtl/clkcfg_shifter.sv
module clkcfg_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift,
   input  logic [WORD_W-1:0] din,
   output logic              msb
);
   logic [WORD_W-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr <= '0;
      end else if (load) begin
         sr <= din;
      end else if (shift) begin
         sr <= {sr[WORD_W-2:0], 1'b0};
      end
   end

   assign msb = sr[WORD_W-1];

   // R4: loading and shifting never collide
   assert_load_xor_shift_R4: assert property (@(posedge clk) disable iff (rst)
      !(load && shift));

endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
   import clkcfg_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 15
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         start,
   input  logic                         period_end,
   output prog_state_t                  state,
   output logic                         load,
   output logic [$clog2(NUM_WORDS)-1:0] load_idx,
   output logic                         shift,
   output logic                         done
);
   localparam int IDX_W = $clog2(NUM_WORDS);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST_W = IDX_W'(NUM_WORDS - 1);
   localparam logic [BIT_W-1:0] LAST_B = BIT_W'(WORD_W - 1);

   logic [IDX_W-1:0] word_idx;
   logic [BIT_W-1:0] bit_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         word_idx <= '0;
         bit_idx  <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_SHIFT;
                  word_idx <= '0;
                  bit_idx  <= '0;
               end
            end
            ST_SHIFT: begin
               if (period_end) begin
                  if (bit_idx == LAST_B) begin
                     state   <= ST_LATCH;
                     bit_idx <= '0;
                  end else begin
                     bit_idx <= bit_idx + BIT_W'(1);
                  end
               end
            end
            ST_LATCH: begin
               if (period_end) begin
                  if (word_idx == LAST_W) begin
                     state    <= ST_IDLE;
                     word_idx <= '0;
                     done     <= 1'b1;
                  end else begin
                     state    <= ST_SHIFT;
                     word_idx <= word_idx + IDX_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load     = 1'b0;
      load_idx = '0;
      if (state == ST_IDLE && start) begin
         load = 1'b1;
      end else if (state == ST_LATCH && period_end && word_idx != LAST_W) begin
         load     = 1'b1;
         load_idx = word_idx + IDX_W'(1);
      end
   end

   assign shift = (state == ST_SHIFT) && period_end && (bit_idx != LAST_B);

   // R2: an idle start request always opens a sequence
   assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && start) |=> (state == ST_SHIFT && word_idx == '0));

   // R9: a start request mid-word leaves the position untouched
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SHIFT && start && !period_end) |=> ($stable(word_idx) && $stable(bit_idx)));

   // R8: done only follows the final latch period
   assert_done_after_latch_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(state) == ST_LATCH && state == ST_IDLE));

endmodule

// File: rtl/clkcfg_serial_prog.sv
module clkcfg_serial_prog
   import clkcfg_pkg::*;
#(
   parameter int              WORD_W     = 32,
   parameter int              HALF_W     = 16,
   parameter int              NUM_WORDS  = 15,
   parameter int              SCLK_DIV   = 25,
   parameter logic [WORD_W-1:0] RESET_WORD = 32'h8000_0000
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            start,
   input  logic [(NUM_WORDS-1)*HALF_W-1:0] cfg_hi,
   input  logic [(NUM_WORDS-1)*HALF_W-1:0] cfg_lo,
   output logic                            sclk,
   output logic                            sdata,
   output logic                            le,
   output logic                            busy,
   output logic                            done
);
   localparam int IDX_W = $clog2(NUM_WORDS);

   if (WORD_W != 2 * HALF_W) begin : g_bad_width
      $error("WORD_W must be twice HALF_W");
   end
   if (NUM_WORDS < 2) begin : g_bad_count
      $error("NUM_WORDS must be at least 2");
   end
   if (SCLK_DIV < 2) begin : g_bad_div
      $error("SCLK_DIV must be at least 2");
   end

   prog_state_t      state;
   logic             period_end;
   logic             high_phase;
   logic             load;
   logic             shift;
   logic [IDX_W-1:0] load_idx;
   logic             msb;
   logic [WORD_W-1:0] word_tbl [NUM_WORDS];

   assign word_tbl[0] = RESET_WORD;
   for (genvar g = 1; g < NUM_WORDS; g++) begin : g_word
      assign word_tbl[g] = {cfg_hi[(g-1)*HALF_W +: HALF_W], cfg_lo[(g-1)*HALF_W +: HALF_W]};
   end

   clkcfg_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_sclk (
      .clk        (clk),
      .rst        (rst),
      .run        (busy),
      .period_end (period_end),
      .high_phase (high_phase)
   );

   clkcfg_seq #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .period_end (period_end),
      .state      (state),
      .load       (load),
      .load_idx   (load_idx),
      .shift      (shift),
      .done       (done)
   );

   clkcfg_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .shift (shift),
      .din   (word_tbl[load_idx]),
      .msb   (msb)
   );

   assign busy  = (state != ST_IDLE);
   assign le    = (state == ST_LATCH);
   assign sclk  = (state == ST_SHIFT) && high_phase;
   assign sdata = (state == ST_SHIFT) && msb;

   // R4: data holds while the serial clock is high
   assert_sdata_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk)) |-> $stable(sdata));

   // R7: the strobe never overlaps a serial clock pulse
   assert_le_no_sclk_R7: assert property (@(posedge clk) disable iff (rst)
      le |-> (!sclk && !sdata));

   // R8: done is a single-cycle pulse that ends busy
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy)));

endmodule

// File: tb/tb_clkcfg_serial_prog.sv
module tb_clkcfg_serial_prog;
   localparam int NW    = 15;
   localparam int W     = 32;
   localparam int H     = 16;
   localparam int DIV   = 25;
   localparam int LOWC  = DIV / 2;
   localparam int SPAN  = (W + 1) * DIV;
   localparam int TOTAL = NW * SPAN;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst, start;
   logic [(NW-1)*H-1:0] cfg_hi, cfg_lo;
   logic sclk, sdata, le, busy, done;

   clkcfg_serial_prog #(.WORD_W(W), .HALF_W(H), .NUM_WORDS(NW), .SCLK_DIV(DIV)) dut (
      .clk(clk), .rst(rst), .start(start), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
      .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .done(done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(int k);
      if (k == 0) return 32'h8000_0000;
      return {cfg_hi[(k-1)*H +: H], cfg_lo[(k-1)*H +: H]};
   endfunction

   task automatic set_pattern(bit inv);
      for (int i = 0; i < NW - 1; i++) begin
         logic [15:0] h, l;
         h = 16'h1000 + 16'(i * 16'h0111);
         l = {8'hA5 ^ 8'(i * 3), 4'h0, 4'(i + 1)};
         cfg_hi[i*H +: H] = inv ? ~h : h;
         cfg_lo[i*H +: H] = inv ? ~l : l;
      end
   endtask

   // behavioural reference: cycle count since the accepted start
   bit m_active;
   int m_t;
   bit m_done;
   always @(posedge clk) begin
      if (rst) begin
         m_active <= 0; m_t <= 0; m_done <= 0;
      end else begin
         m_done <= 0;
         if (m_active) begin
            if (m_t == TOTAL - 1) begin m_active <= 0; m_done <= 1; end
            else m_t <= m_t + 1;
         end else if (start) begin
            m_active <= 1; m_t <= 0;
         end
      end
   end

   bit cmp_on = 0;
   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         logic e_sclk, e_sdata, e_le;
         e_sclk = 0; e_sdata = 0; e_le = 0;
         if (m_active) begin
            int w, r, b, c;
            w = m_t / SPAN; r = m_t % SPAN; b = r / DIV; c = r % DIV;
            if (b < W) begin
               e_sclk = (c >= LOWC);
               e_sdata = exp_word(w)[W-1-b];
            end else begin
               e_le = 1;
            end
         end
         chk(sclk == e_sclk, "R3 sclk timing", 32'(sclk), 32'(e_sclk));
         chk(sdata == e_sdata, "R4 sdata bit", 32'(sdata), 32'(e_sdata));
         chk(le == e_le, "R7 latch enable", 32'(le), 32'(e_le));
         chk(busy == m_active, "R8 busy", 32'(busy), 32'(m_active));
         chk(done == m_done, "R8 done", 32'(done), 32'(m_done));
      end
   end

   // independent serial receiver
   logic [31:0] rxsr = '0;
   int rx_total = 0;
   int rx_mark = 0;
   logic [31:0] rxq [$];
   always @(posedge sclk) begin
      rxsr = {rxsr[30:0], sdata};
      rx_total++;
   end
   always @(posedge le) begin
      rxq.push_back(rxsr);
      chk((rx_total - rx_mark) == W, "R7 bits per strobe", 32'(rx_total - rx_mark), 32'(W));
      rx_mark = rx_total;
   end

   task automatic verify_words(string tag);
      chk(rxq.size() == NW, {tag, " R8 word count"}, 32'(rxq.size()), 32'(NW));
      for (int k = 0; k < NW && k < rxq.size(); k++) begin
         chk(rxq[k] == exp_word(k), (k == 0) ? {tag, " R5 reset word"} : {tag, " R6 word"},
             rxq[k], exp_word(k));
      end
      rxq.delete();
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         finish_run();
      end
   end

   initial begin
      int t0;
      rst = 1; start = 0;
      set_pattern(0);
      repeat (5) @(negedge clk);
      chk({sclk, sdata, le, busy, done} == 5'b0, "R1 reset outputs", 32'({sclk, sdata, le, busy, done}), 0);
      rst = 0;
      @(negedge clk);
      chk({sclk, sdata, le, busy, done} == 5'b0, "R1 idle after reset", 32'({sclk, sdata, le, busy, done}), 0);
      cmp_on = 1;
      repeat (4) @(negedge clk);

      // sequence 1, pattern A
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
      chk(sclk == 1'b0 && sdata == 1'b1, "R2 first bit sclk low", 32'({sclk, sdata}), 32'b01);
      t0 = cyc;
      wait_done();
      chk((cyc - t0) == TOTAL, "R8 sequence length", 32'(cyc - t0), 32'(TOTAL));
      chk(busy == 1'b0, "R8 busy falls with done", 32'(busy), 0);
      verify_words("seq1");
      repeat (10) @(negedge clk);

      // sequence 2, pattern B, with a start request mid-sequence
      set_pattern(1);
      start = 1;
      @(negedge clk);
      start = 0;
      repeat (3000) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      t0 = cyc;
      wait_done();
      chk((cyc - t0) == TOTAL - 3001, "R9 timing unchanged by start", 32'(cyc - t0), 32'(TOTAL - 3001));
      chk(rxq.size() == NW, "R9 no restart", 32'(rxq.size()), 32'(NW));
      verify_words("seq2");

      // sequence 3: start in the done cycle
      set_pattern(0);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy == 1'b1, "R9 start on done accepted", 32'(busy), 1);
      wait_done();
      verify_words("seq3");
      repeat (20) @(negedge clk);
      chk({sclk, sdata, le, busy, done} == 5'b0, "R8 idle after sequence", 32'({sclk, sdata, le, busy, done}), 0);
      finish_run();
   end
endmodule